// File: doc/BRIEF.md
# Core module system control register block

This block holds the 32-bit memory-mapped control and status registers of a processor core module. A host reaches it through a simple word-addressed bus: one select strobe, a write flag, a word address and 32-bit write data. Writes take effect at the clock edge that samples the strobe. Read data and an error flag are registered and appear one cycle after the read strobe.

The register set covers several jobs. It gives a fixed identity word and read-only status. Two oscillator setting words can be written only while a 16-bit unlock key sits in the lock word. A control word drives a green LED, a boot-remap level and a one-cycle board-reset request. Two flag banks, one volatile and one non-volatile, are changed through separate set and clear offsets. A small interrupt section has a software-raised interrupt line with separate IRQ and FIQ enable masks. A read-only window returns the bytes of the fitted memory's serial-presence-detect table, one byte per word.

The installed memory size is a parameter. It selects the size code in the SDRAM word and the size byte of the presence-detect table.

Top module: `cm_sysctl`

## Requirements
- R1: A read returns its data on `bus_rdata` in the cycle after the strobe. Word 0 reads 0x411A3001, word 1 reads 0 and word 4 reads 0x00100000.
- R2: After reset, the registers hold these values: OSC (word 2) 0x01000048, AUXOSC (word 7) 0x0007FEFF, INIT (word 9) 0x00000112, and SDRAM (word 8) 0x00011122 ORed with a size code. The size code is 0x10 for MEM_MB ≥ 256, 0x0C for ≥ 128, 0x08 for ≥ 64, 0x04 for ≥ 32 and 0 below that. Also after reset, CTRL, LOCK, both flag banks, both enable masks and the interrupt level are zero, and `led_o`, `remap_o`, `board_rst_o`, `irq_o` and `fiq_o` are low.
- R3: A write to word 5 keeps only the low 16 bits. When the kept value is 0xA05F, word 5 reads 0x0001A05F. Otherwise it reads the kept value.
- R4: Writes to words 2 and 7 are stored only while word 5 holds 0xA05F. At any other time they are dropped.
- R5: Words 8 (SDRAM) and 9 (INIT) store and return any full 32-bit value.
- R6: A write to word 12 ORs the data into the volatile flags, and a write to word 13 clears the flag bits where the data is 1. Words 14 and 15 do the same for the non-volatile flags. Words 12 and 14 read the current values.
- R7: A write to word 3 stores the word with bit 3 forced to 0. `led_o` follows stored bit 0. `remap_o` follows stored bit 2 (0 selects flash at address zero). If the written bit 3 is 1, `board_rst_o` goes high for exactly one cycle.
- R8: The interrupt section works as follows:
  - The interrupt level is one bit, at bit 0. A write to word 20 with data bit 0 set raises it, and a write to word 21 with data bit 0 set lowers it. Other data bits are ignored.
  - Words 18/19 set and clear bits of the IRQ mask. Words 26/27 do the same for the FIQ mask.
  - Reads return these values: word 16 gives level AND IRQ mask, word 24 gives level AND FIQ mask, words 17 and 25 give the level, word 20 gives the level, and words 18 and 26 give the masks.
  - `irq_o` and `fiq_o` are high when their masked status is non-zero.
- R9: Words 64–95 return the presence-detect byte whose index is the word number minus 64, zero-extended. Byte 0 is 128, byte 9 is 0xA0, and byte 31 is the size byte (64, 32, 16, 4 or 2 for the size bands of R2). Bytes 32 and above are zero. Words 96–127 read 0.
- R10: Words 32–35 read 0 without error, and writes to them change nothing.
- R11: A read of any word not listed in R1–R10 returns 0 and raises `bus_err` for one cycle. This includes words 6, 10, 11, 13, 15, 19, 21 and 27. A write to such a word changes no register and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for a read of an unmapped word |
| led_o | output | 1 | Green LED drive |
| remap_o | output | 1 | Boot remap level, 0 = flash at address zero |
| board_rst_o | output | 1 | One-cycle board reset request |
| irq_o | output | 1 | Module IRQ request |
| fiq_o | output | 1 | Module FIQ request |

## Verification
The bench builds the block with MEM_MB = 64 so that the memory-size decode lands in a band that is neither the lowest nor the highest. The SDRAM reset word is then expected to be 0x0001112A and presence-detect byte 31 is expected to be 16. Those two values confirm that the size comparison picks the correct threshold and does not fall through to the default. The address width stays at 7 bits, which reaches the whole register space, the presence-detect window and its zero tail.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;

    localparam int DW = 32;

    // word offsets (software-visible map)
    localparam int W_IDENT   = 0;
    localparam int W_PROC    = 1;
    localparam int W_OSC     = 2;
    localparam int W_CTRL    = 3;
    localparam int W_STAT    = 4;
    localparam int W_LOCK    = 5;
    localparam int W_AUXOSC  = 7;
    localparam int W_SDRAM   = 8;
    localparam int W_INIT    = 9;
    localparam int W_FLG_SET = 12;
    localparam int W_FLG_CLR = 13;
    localparam int W_NVF_SET = 14;
    localparam int W_NVF_CLR = 15;
    localparam int W_IRQ_ST  = 16;
    localparam int W_IRQ_RAW = 17;
    localparam int W_IRQ_ES  = 18;
    localparam int W_IRQ_EC  = 19;
    localparam int W_SW_SET  = 20;
    localparam int W_SW_CLR  = 21;
    localparam int W_FIQ_ST  = 24;
    localparam int W_FIQ_RAW = 25;
    localparam int W_FIQ_ES  = 26;
    localparam int W_FIQ_EC  = 27;
    localparam int W_VOLT_LO = 32;
    localparam int W_VOLT_HI = 35;
    localparam int W_SPD_LO  = 64;
    localparam int W_SPD_HI  = 127;

    localparam logic [DW-1:0] IDENT_WORD = 32'h411A_3001;
    localparam logic [DW-1:0] STAT_WORD  = 32'h0010_0000;
    localparam logic [15:0]   UNLOCK_KEY = 16'hA05F;
    localparam logic [DW-1:0] OSC_RST    = 32'h0100_0048;
    localparam logic [DW-1:0] AUX_RST    = 32'h0007_FEFF;
    localparam logic [DW-1:0] INIT_RST   = 32'h0000_0112;
    localparam logic [DW-1:0] SDRAM_BASE = 32'h0001_1122;

    typedef struct packed {
        logic          sel;
        logic          wr;
        int unsigned   idx;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic logic [DW-1:0] sdram_reset(input int mb);
        logic [DW-1:0] code;
        if (mb >= 256)      code = 32'h10;
        else if (mb >= 128) code = 32'h0C;
        else if (mb >= 64)  code = 32'h08;
        else if (mb >= 32)  code = 32'h04;
        else                code = 32'h00;
        return SDRAM_BASE | code;
    endfunction

    function automatic logic [7:0] size_byte(input int mb);
        if (mb >= 256)      return 8'd64;
        else if (mb >= 128) return 8'd32;
        else if (mb >= 64)  return 8'd16;
        else if (mb >= 32)  return 8'd4;
        else                return 8'd2;
    endfunction

    function automatic logic [7:0] spd_byte(input int mb, input int unsigned i);
        case (i)
            0:  return 8'd128;  1:  return 8'd8;    2:  return 8'd4;    3:  return 8'd11;
            4:  return 8'd9;    5:  return 8'd1;    6:  return 8'd64;   8:  return 8'd2;
            9:  return 8'hA0;   10: return 8'hA0;   13: return 8'd8;    15: return 8'd1;
            16: return 8'h0E;   17: return 8'd4;    18: return 8'h1C;   19: return 8'd1;
            20: return 8'd2;    21: return 8'h20;   22: return 8'hC0;   27: return 8'h30;
            28: return 8'h28;   29: return 8'h30;   30: return 8'h28;
            31: return size_byte(mb);
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (set_we) q <= q | wdata;
        else if (clr_we) q <= q & ~wdata;
    end
endmodule

// File: rtl/cm_lock_osc.sv
module cm_lock_osc
    import cm_sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          lock_we,
    input  logic          osc_we,
    input  logic          aux_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] lock_rd,
    output logic [DW-1:0] osc_q,
    output logic [DW-1:0] aux_q,
    output logic          unlocked
);
    logic [15:0] key_q;

    assign unlocked = (key_q == UNLOCK_KEY);
    assign lock_rd  = {15'd0, unlocked, key_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            osc_q <= OSC_RST;
            aux_q <= AUX_RST;
        end else begin
            if (lock_we)             key_q <= wdata[15:0];
            if (osc_we && unlocked)  osc_q <= wdata;
            if (aux_we && unlocked)  aux_q <= wdata;
        end
    end
endmodule

// File: rtl/cm_ctrl.sv
module cm_ctrl
    import cm_sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] ctrl_q,
    output logic          led_o,
    output logic          remap_o,
    output logic          board_rst_o
);
    localparam int B_LED = 0;
    localparam int B_MAP = 2;
    localparam int B_RST = 3;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            board_rst_o <= 1'b0;
        end else begin
            board_rst_o <= we && wdata[B_RST];
            if (we) begin
                ctrl_q        <= wdata;
                ctrl_q[B_RST] <= 1'b0;
            end
        end
    end

    assign led_o   = ctrl_q[B_LED];
    assign remap_o = ctrl_q[B_MAP];
endmodule

// File: rtl/cm_intr.sv
module cm_intr
    import cm_sysctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_set_we,
    input  logic          irq_clr_we,
    input  logic          fiq_set_we,
    input  logic          fiq_clr_we,
    input  logic          sw_set_we,
    input  logic          sw_clr_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] level,
    output logic [DW-1:0] irq_en,
    output logic [DW-1:0] fiq_en,
    output logic          irq_o,
    output logic          fiq_o
);
    logic sw_q;

    cm_setclr_reg #(.W(DW)) u_irq_en (
        .clk(clk), .rst(rst), .set_we(irq_set_we), .clr_we(irq_clr_we),
        .wdata(wdata), .q(irq_en));

    cm_setclr_reg #(.W(DW)) u_fiq_en (
        .clk(clk), .rst(rst), .set_we(fiq_set_we), .clr_we(fiq_clr_we),
        .wdata(wdata), .q(fiq_en));

    always_ff @(posedge clk) begin
        if (rst)                         sw_q <= 1'b0;
        else if (sw_set_we && wdata[0])  sw_q <= 1'b1;
        else if (sw_clr_we && wdata[0])  sw_q <= 1'b0;
    end

    assign level = {{(DW-1){1'b0}}, sw_q};
    assign irq_o = |(level & irq_en);
    assign fiq_o = |(level & fiq_en);
endmodule

// File: rtl/cm_sysctl.sv
module cm_sysctl
    import cm_sysctl_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int MEM_MB = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              bus_err,
    output logic              led_o,
    output logic              remap_o,
    output logic              board_rst_o,
    output logic              irq_o,
    output logic              fiq_o
);
    localparam logic [DW-1:0] SDRAM_RST = sdram_reset(MEM_MB);
    localparam int FLAG_BANKS = 2;

    bus_req_t req;
    logic     wr_act;
    assign req    = '{sel: bus_sel, wr: bus_wr, idx: 32'(bus_addr), data: bus_wdata};
    assign wr_act = req.sel && req.wr;

    logic [DW-1:0] lock_rd, osc_q, aux_q, ctrl_q, sdram_q, init_q;
    logic [DW-1:0] level, irq_en, fiq_en;
    logic          unlocked;
    logic [DW-1:0] flag_q [FLAG_BANKS];
    logic [DW-1:0] flags_q;
    assign flags_q = flag_q[0];

    cm_lock_osc u_lock (
        .clk(clk), .rst(rst),
        .lock_we(wr_act && req.idx == W_LOCK),
        .osc_we (wr_act && req.idx == W_OSC),
        .aux_we (wr_act && req.idx == W_AUXOSC),
        .wdata(req.data), .lock_rd(lock_rd), .osc_q(osc_q), .aux_q(aux_q),
        .unlocked(unlocked));

    cm_ctrl u_ctrl (
        .clk(clk), .rst(rst), .we(wr_act && req.idx == W_CTRL), .wdata(req.data),
        .ctrl_q(ctrl_q), .led_o(led_o), .remap_o(remap_o), .board_rst_o(board_rst_o));

    cm_intr u_intr (
        .clk(clk), .rst(rst),
        .irq_set_we(wr_act && req.idx == W_IRQ_ES),
        .irq_clr_we(wr_act && req.idx == W_IRQ_EC),
        .fiq_set_we(wr_act && req.idx == W_FIQ_ES),
        .fiq_clr_we(wr_act && req.idx == W_FIQ_EC),
        .sw_set_we (wr_act && req.idx == W_SW_SET),
        .sw_clr_we (wr_act && req.idx == W_SW_CLR),
        .wdata(req.data), .level(level), .irq_en(irq_en), .fiq_en(fiq_en),
        .irq_o(irq_o), .fiq_o(fiq_o));

    // flag banks: bank b uses set offset W_FLG_SET + 2b, clear offset one above
    for (genvar b = 0; b < FLAG_BANKS; b++) begin : g_flag
        localparam int SET_OFF = W_FLG_SET + 2 * b;
        cm_setclr_reg #(.W(DW)) u_bank (
            .clk(clk), .rst(rst),
            .set_we(wr_act && req.idx == SET_OFF),
            .clr_we(wr_act && req.idx == SET_OFF + 1),
            .wdata(req.data), .q(flag_q[b]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdram_q <= SDRAM_RST;
            init_q  <= INIT_RST;
        end else begin
            if (wr_act && req.idx == W_SDRAM) sdram_q <= req.data;
            if (wr_act && req.idx == W_INIT)  init_q  <= req.data;
        end
    end

    // read decode
    logic [DW-1:0] rd_mux;
    logic          rd_hit;
    always_comb begin
        rd_mux = '0;
        rd_hit = 1'b1;
        if (req.idx >= W_SPD_LO && req.idx <= W_SPD_HI) begin
            rd_mux = {24'd0, spd_byte(MEM_MB, req.idx - W_SPD_LO)};
        end else if (req.idx >= W_VOLT_LO && req.idx <= W_VOLT_HI) begin
            rd_mux = '0;
        end else begin
            case (req.idx)
                W_IDENT:   rd_mux = IDENT_WORD;
                W_PROC:    rd_mux = '0;
                W_OSC:     rd_mux = osc_q;
                W_CTRL:    rd_mux = ctrl_q;
                W_STAT:    rd_mux = STAT_WORD;
                W_LOCK:    rd_mux = lock_rd;
                W_AUXOSC:  rd_mux = aux_q;
                W_SDRAM:   rd_mux = sdram_q;
                W_INIT:    rd_mux = init_q;
                W_FLG_SET: rd_mux = flag_q[0];
                W_NVF_SET: rd_mux = flag_q[1];
                W_IRQ_ST:  rd_mux = level & irq_en;
                W_IRQ_RAW: rd_mux = level;
                W_IRQ_ES:  rd_mux = irq_en;
                W_SW_SET:  rd_mux = level;
                W_FIQ_ST:  rd_mux = level & fiq_en;
                W_FIQ_RAW: rd_mux = level;
                W_FIQ_ES:  rd_mux = fiq_en;
                default:   rd_hit = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= (req.sel && !req.wr) ? rd_mux : '0;
            bus_err   <= req.sel && !req.wr && !rd_hit;
        end
    end
endmodule

// File: rtl/cm_sysctl_chk.sv
module cm_sysctl_chk
    import cm_sysctl_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              bus_err,
    input logic              board_rst_o,
    input logic              remap_o,
    input logic              irq_o,
    input logic              unlocked,
    input logic [DW-1:0]     osc_q,
    input logic [DW-1:0]     flags_q
);
    assert_osc_locked_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !unlocked) |=> $stable(osc_q));

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && 32'(bus_addr) == W_FLG_CLR) |=> ((flags_q & $past(bus_wdata)) == '0));

    assert_reset_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        board_rst_o |=> !board_rst_o);

    assert_remap_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr && 32'(bus_addr) == W_CTRL) |=> $stable(remap_o));

    assert_soft_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && 32'(bus_addr) == W_SW_SET && bus_wdata[0]) |=> irq_o == $past(irq_o) || irq_o);

    assert_err_after_read_R11: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_sel && !bus_wr));
endmodule

bind cm_sysctl cm_sysctl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_err(bus_err), .board_rst_o(board_rst_o),
    .remap_o(remap_o), .irq_o(irq_o), .unlocked(unlocked), .osc_q(osc_q),
    .flags_q(flags_q));

// File: tb/cm_sysctl_tb_top.sv
module cm_sysctl_tb_top;
    localparam int AW = 7;
    localparam int MB = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_err, led_o, remap_o, board_rst_o, irq_o, fiq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cm_sysctl #(.ADDR_W(AW), .MEM_MB(MB)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .led_o(led_o), .remap_o(remap_o), .board_rst_o(board_rst_o),
        .irq_o(irq_o), .fiq_o(fiq_o));

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        e = bus_err;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        logic [31:0] d; logic e;
        rd(a, d, e);
        check(req, d, exp);
        check({req, " err"}, 32'(e), 32'd0);
    endtask

    task automatic t_reset;
        check("R2 led", 32'(led_o), 0);
        check("R2 remap", 32'(remap_o), 0);
        check("R2 rst pulse", 32'(board_rst_o), 0);
        check("R2 irq", 32'(irq_o), 0);
        check("R2 fiq", 32'(fiq_o), 0);
        rd_chk("R2 osc", 2, 32'h0100_0048);
        rd_chk("R2 auxosc", 7, 32'h0007_FEFF);
        rd_chk("R2 init", 9, 32'h0000_0112);
        rd_chk("R2 sdram", 8, 32'h0001_112A);
        rd_chk("R2 ctrl", 3, 0);
        rd_chk("R2 lock", 5, 0);
        rd_chk("R2 flags", 12, 0);
        rd_chk("R2 nvflags", 14, 0);
    endtask

    task automatic t_ident;
        rd_chk("R1 id", 0, 32'h411A_3001);
        rd_chk("R1 proc", 1, 0);
        rd_chk("R1 stat", 4, 32'h0010_0000);
    endtask

    task automatic t_lock;
        wr(2, 32'h0000_1234);
        rd_chk("R4 osc locked", 2, 32'h0100_0048);
        wr(5, 32'h1234_A05F);
        rd_chk("R3 lock key", 5, 32'h0001_A05F);
        wr(2, 32'hCAFE_0001);
        rd_chk("R4 osc unlocked", 2, 32'hCAFE_0001);
        wr(7, 32'h0000_0055);
        rd_chk("R4 aux unlocked", 7, 32'h0000_0055);
        wr(5, 32'hFFFF_1234);
        rd_chk("R3 lock other", 5, 32'h0000_1234);
        wr(7, 32'h0000_0077);
        rd_chk("R4 aux relocked", 7, 32'h0000_0055);
        wr(5, 0);
    endtask

    task automatic t_plain;
        wr(8, 32'hDEAD_BEEF);
        rd_chk("R5 sdram", 8, 32'hDEAD_BEEF);
        wr(9, 32'h8000_0001);
        rd_chk("R5 init", 9, 32'h8000_0001);
    endtask

    task automatic t_flags;
        wr(12, 32'h0000_F0F0);
        rd_chk("R6 flags set", 12, 32'h0000_F0F0);
        wr(13, 32'h0000_00F0);
        rd_chk("R6 flags clr", 12, 32'h0000_F000);
        wr(12, 32'h0000_0001);
        rd_chk("R6 flags or", 12, 32'h0000_F001);
        wr(14, 32'h0000_000A);
        wr(15, 32'h0000_0002);
        rd_chk("R6 nvflags", 14, 32'h0000_0008);
        rd_chk("R6 banks apart", 12, 32'h0000_F001);
    endtask

    task automatic t_ctrl;
        wr(3, 32'h0000_0005);
        check("R7 led on", 32'(led_o), 1);
        check("R7 remap on", 32'(remap_o), 1);
        check("R7 no pulse", 32'(board_rst_o), 0);
        rd_chk("R7 ctrl read", 3, 32'h0000_0005);
        wr(3, 32'h0000_000D);
        check("R7 pulse high", 32'(board_rst_o), 1);
        @(negedge clk);
        check("R7 pulse one cycle", 32'(board_rst_o), 0);
        rd_chk("R7 bit3 masked", 3, 32'h0000_0005);
        wr(3, 0);
        check("R7 led off", 32'(led_o), 0);
        check("R7 remap off", 32'(remap_o), 0);
    endtask

    task automatic t_intr;
        wr(18, 32'h0000_0001);
        check("R8 irq no level", 32'(irq_o), 0);
        wr(20, 32'hFFFF_FFFE);
        rd_chk("R8 soft bit0 only", 17, 0);
        wr(20, 32'h0000_0001);
        check("R8 irq high", 32'(irq_o), 1);
        check("R8 fiq low", 32'(fiq_o), 0);
        rd_chk("R8 irq stat", 16, 1);
        rd_chk("R8 raw", 17, 1);
        rd_chk("R8 soft read", 20, 1);
        rd_chk("R8 fiq stat", 24, 0);
        wr(26, 32'h0000_0003);
        check("R8 fiq high", 32'(fiq_o), 1);
        rd_chk("R8 fiq en", 26, 3);
        rd_chk("R8 fiq raw", 25, 1);
        wr(27, 32'h0000_0001);
        check("R8 fiq masked", 32'(fiq_o), 0);
        rd_chk("R8 fiq en clr", 26, 2);
        wr(18, 32'h0000_00F0);
        rd_chk("R8 irq en", 18, 32'h0000_00F1);
        wr(19, 32'h0000_0001);
        check("R8 irq masked", 32'(irq_o), 0);
        wr(18, 32'h0000_0001);
        wr(21, 32'h0000_0001);
        check("R8 irq cleared", 32'(irq_o), 0);
        rd_chk("R8 raw cleared", 17, 0);
    endtask

    task automatic t_spd;
        rd_chk("R9 byte0", 64, 128);
        rd_chk("R9 byte9", 73, 32'hA0);
        rd_chk("R9 size byte", 95, 16);
        rd_chk("R9 tail", 96, 0);
        rd_chk("R9 tail end", 127, 0);
    endtask

    task automatic t_volt;
        wr(33, 32'hFFFF_FFFF);
        rd_chk("R10 volt", 33, 0);
        rd_chk("R10 volt hi", 35, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d; logic e;
        rd(6, d, e);
        check("R11 data", d, 0);
        check("R11 err", 32'(e), 1);
        @(negedge clk);
        check("R11 err one cycle", 32'(bus_err), 0);
        rd(13, d, e);
        check("R11 clr offset err", 32'(e), 1);
        wr(11, 32'hFFFF_FFFF);
        check("R11 write no err", 32'(bus_err), 0);
        rd_chk("R11 flags untouched", 12, 32'h0000_F001);
        rd_chk("R11 init untouched", 9, 32'h8000_0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ident();
        t_lock();
        t_plain();
        t_flags();
        t_ctrl();
        t_intr();
        t_spd();
        t_volt();
        t_unmapped();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule